// File: doc/BRIEF.md
# Gateway-Driven MDIO Clause 22 Management Master

This block is a management-bus master for Ethernet PHYs. Software writes one 32-bit command word into a gateway register. The block then runs exactly one Clause 22 read or write frame on the MDC clock and MDIO data lines. The same gateway word carries the command fields, the busy flag and, once a read has finished, the 16 bits returned by the PHY. Software polls the busy flag until it reads 0 and then keeps the low half-word.

A second register sets the timing, counted in core clock cycles. It holds the MDC half-period value and two offsets: one for the cycle in the low half of each MDC period at which the block drives MDIO, and one for the cycle in the high half at which it samples MDIO. MDIO is a tri-state pin, so the block presents a data output, an output enable and a data input. Registers are reached over a minimal write-strobe bus with a combinational read mux.

Top module: `mdio_gw_master`

## Requirements
- R1: After reset the gateway reads 0x00000000 and the timing register reads 0x0D065500 (drive offset 13, sample offset 6, period value 85, option bits 0). MDC and the MDIO output enable are low.
- R2: The gateway is at byte offset 0x0 and the timing register at 0x4. The gateway reads back as bit 30 busy, bit 28 start marker, bits 27:26 opcode, bits 25:21 PHY address, bits 20:16 register number, bits 15:0 data. The timing register reads back as bits 31:24 drive offset, 23:16 sample offset, 15:8 period value, bit 4 full-drive, bit 2 3.3 V select, bits 1:0 mode. Bits not listed here read 0, and writes to any other offset change nothing.
- R3: A gateway write with bit 30 set while idle starts a frame, and busy reads 1 until that frame ends. A gateway write with bit 30 clear only stores the fields and starts no frame.
- R4: Every frame has 64 MDC rising edges. The frame is 32 ones, then 01, the opcode, the PHY address and the register number, each sent MSB first. For any opcode other than 10, the frame continues with 10 and the 16 data bits, and MDIO is driven for the whole frame.
- R5: For opcode 10 (read), the output enable is low from bit 46 (the first turnaround bit) to the end of the frame. The 16 bits sampled from bit 48 onward, MSB first, replace gateway bits 15:0 when the frame completes.
- R6: The MDC period is 2*(value+1) core cycles: first value+1 cycles low, then value+1 cycles high. MDC stays low while idle.
- R7: MDIO output and enable update on the clock edge that ends low-half cycle k, where k is the drive offset clamped to the period value. The output enable therefore first rises k+1 cycles after the accepted command write, and MDIO does not change while MDC is high.
- R8: MDIO input is captured on the clock edge that ends high-half cycle j, where j is the sample offset clamped to the period value.
- R9: While busy, a gateway write with any non-zero value is ignored. The command fields and the frame on the wire do not change.
- R10: A gateway write of 0x00000000 while busy cancels the frame. On the next cycle busy is 0, the gateway word is 0, and MDC and the output enable are low. A cancel in the same cycle as frame completion wins over the completion.
- R11: The mode, 3.3 V select and full-drive bits are readable and writable storage only. They do not change frame content or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe_o | output | 1 | MDIO pad output enable |

## Verification
Two events can fall on the same clock edge: a software gateway write and the internal end of a frame. The bench computes the exact edge on which the 64th bit period closes. It then lands a gateway write on that edge twice: once with a non-zero command, which must be dropped while the completed frame's fields survive, and once with the all-zero cancel word, which must leave the gateway at zero. Both outcomes are judged from the gateway readback and from the absence of any further MDC edges.

// File: rtl/mdio_gw_pkg.sv
`timescale 1ns/1ps
package mdio_gw_pkg;
  localparam int unsigned FLD_W = 8;
  localparam logic [1:0]  OP_RD = 2'b10;

  typedef struct packed {
    logic       st;
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] regn;
    logic [15:0] data;
  } gw_cmd_t;

  typedef struct packed {
    logic [FLD_W-1:0] out_ofs;
    logic [FLD_W-1:0] smp_ofs;
    logic [FLD_W-1:0] div;
    logic             full_drv;
    logic             sel33;
    logic [1:0]       mode;
  } cfg_t;
endpackage

// File: rtl/mdio_phase_gen.sv
`timescale 1ns/1ps
module mdio_phase_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] out_ofs_i,
  input  logic [DIV_W-1:0] smp_ofs_i,
  output logic             mdc_o,
  output logic             drv_stb_o,
  output logic             smp_stb_o,
  output logic             end_stb_o
);
  localparam int unsigned PH_W = DIV_W + 1;

  logic [PH_W-1:0]  ph_q, last_ph, drv_ph, smp_ph;
  logic [DIV_W-1:0] out_eff, smp_eff;

  // offsets beyond the half period are pinned to its last cycle
  assign out_eff = (out_ofs_i > div_i) ? div_i : out_ofs_i;
  assign smp_eff = (smp_ofs_i > div_i) ? div_i : smp_ofs_i;
  assign last_ph = {div_i, 1'b1};
  assign drv_ph  = {1'b0, out_eff};
  assign smp_ph  = {1'b0, div_i} + {1'b0, smp_eff} + PH_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ph_q <= '0;
    else if (!run_i || ph_q == last_ph) ph_q <= '0;
    else                                ph_q <= ph_q + PH_W'(1);
  end

  assign mdc_o     = run_i && (ph_q > {1'b0, div_i});
  assign drv_stb_o = run_i && (ph_q == drv_ph);
  assign smp_stb_o = run_i && (ph_q == smp_ph);
  assign end_stb_o = run_i && (ph_q == last_ph);
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_gw_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        abort_i,
  input  logic [1:0]  op_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        drv_stb_i,
  input  logic        smp_stb_i,
  input  logic        end_stb_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        done_o,
  output logic [15:0] rdata_o
);
  localparam int unsigned HDR_LEN   = 32;
  localparam int unsigned FRAME_LEN = PRE_LEN + HDR_LEN;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN + 1);
  localparam int unsigned TA_IDX    = PRE_LEN + 14;
  localparam int unsigned DAT_IDX   = PRE_LEN + 16;

  logic [IDX_W-1:0]   idx_q;
  logic [HDR_LEN-1:0] sh_q;
  logic [15:0]        rx_q, rx_nxt;
  logic               out_q, oe_q, rd_q;
  logic               in_pre, last_bit, cur_bit, smp_now;

  assign in_pre   = idx_q < IDX_W'(PRE_LEN);
  assign last_bit = idx_q == IDX_W'(FRAME_LEN - 1);
  assign cur_bit  = in_pre ? 1'b1 : sh_q[HDR_LEN-1];
  assign smp_now  = smp_stb_i && rd_q && (idx_q >= IDX_W'(DAT_IDX));
  // last sample may share the edge with frame end
  assign rx_nxt   = smp_now ? {rx_q[14:0], mdio_i} : rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sh_q  <= '0;
      rx_q  <= '0;
      out_q <= 1'b1;
      oe_q  <= 1'b0;
      rd_q  <= 1'b0;
    end else if (abort_i) begin
      idx_q <= '0;
      out_q <= 1'b1;
      oe_q  <= 1'b0;
    end else if (start_i) begin
      idx_q <= '0;
      sh_q  <= {2'b01, op_i, phy_i, reg_i, (op_i == OP_RD) ? 2'b11 : 2'b10, wdata_i};
      rd_q  <= (op_i == OP_RD);
      rx_q  <= '0;
    end else begin
      rx_q <= rx_nxt;
      if (drv_stb_i) begin
        out_q <= cur_bit;
        oe_q  <= !(rd_q && idx_q >= IDX_W'(TA_IDX));
      end
      if (end_stb_i) begin
        if (last_bit) begin
          idx_q <= '0;
          oe_q  <= 1'b0;
          out_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          if (!in_pre) sh_q <= sh_q << 1;
        end
      end
    end
  end

  assign done_o    = end_stb_i && last_bit;
  assign rdata_o   = rx_nxt;
  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;
endmodule

// File: rtl/mdio_gw_master.sv
`timescale 1ns/1ps
module mdio_gw_master
  import mdio_gw_pkg::*;
#(
  parameter int unsigned     ADDR_W  = 4,
  parameter int unsigned     PRE_LEN = 32,
  parameter logic [FLD_W-1:0] RST_DIV = 8'd85,
  parameter logic [FLD_W-1:0] RST_SMP = 8'd6,
  parameter logic [FLD_W-1:0] RST_OUT = 8'd13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mdc_o,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam logic [ADDR_W-1:0] GW_OFS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CFG_OFS = ADDR_W'(4);

  gw_cmd_t cmd_q, cmd_in;
  cfg_t    cfg_q;
  logic    busy_q;
  logic    gw_wr, cfg_wr, cancel, start, done;
  logic    drv_stb, smp_stb, end_stb;
  logic [15:0] rx_data;

  assign cmd_in = gw_cmd_t'(reg_wdata_i[28:0]);
  assign gw_wr  = reg_wr_i && (reg_addr_i == GW_OFS);
  assign cfg_wr = reg_wr_i && (reg_addr_i == CFG_OFS);
  assign cancel = gw_wr && busy_q && (reg_wdata_i == 32'h0);
  assign start  = gw_wr && !busy_q && reg_wdata_i[30];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
    end else if (cancel) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
      if (cmd_q.op == OP_RD) cmd_q.data <= rx_data;
    end else if (gw_wr && !busy_q) begin
      busy_q <= reg_wdata_i[30];
      cmd_q  <= cmd_in;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{out_ofs: RST_OUT, smp_ofs: RST_SMP, div: RST_DIV,
                 full_drv: 1'b0, sel33: 1'b0, mode: 2'b00};
    end else if (cfg_wr) begin
      cfg_q <= '{out_ofs: reg_wdata_i[31:24], smp_ofs: reg_wdata_i[23:16],
                 div: reg_wdata_i[15:8], full_drv: reg_wdata_i[4],
                 sel33: reg_wdata_i[2], mode: reg_wdata_i[1:0]};
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == GW_OFS)
      reg_rdata_o = {1'b0, busy_q, 1'b0, cmd_q};
    else if (reg_addr_i == CFG_OFS)
      reg_rdata_o = {cfg_q.out_ofs, cfg_q.smp_ofs, cfg_q.div, 3'b000,
                     cfg_q.full_drv, 1'b0, cfg_q.sel33, cfg_q.mode};
  end

  mdio_phase_gen #(.DIV_W(FLD_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_q),
    .div_i     (cfg_q.div),
    .out_ofs_i (cfg_q.out_ofs),
    .smp_ofs_i (cfg_q.smp_ofs),
    .mdc_o     (mdc_o),
    .drv_stb_o (drv_stb),
    .smp_stb_o (smp_stb),
    .end_stb_o (end_stb)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .abort_i   (cancel),
    .op_i      (cmd_in.op),
    .phy_i     (cmd_in.phy),
    .reg_i     (cmd_in.regn),
    .wdata_i   (cmd_in.data),
    .drv_stb_i (drv_stb),
    .smp_stb_i (smp_stb),
    .end_stb_i (end_stb),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .rdata_o   (rx_data)
  );
endmodule

// File: rtl/mdio_gw_chk.sv
`timescale 1ns/1ps
module mdio_gw_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic              busy_q,
  input logic [28:0]       cmd_q
);
  logic gw_wr;
  assign gw_wr = reg_wr_i && (reg_addr_i == ADDR_W'(0));

  a_r6_mdc_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mdc_o);

  a_r1_oe_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mdio_oe_o);

  a_r3_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_wr && !busy_q && reg_wdata_i[30]) |=> busy_q);

  a_r9_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_wr && busy_q && reg_wdata_i != 32'h0) |=> (!busy_q || $stable(cmd_q)));

  a_r10_cancel_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_wr && busy_q && reg_wdata_i == 32'h0) |=> (!busy_q && cmd_q == 29'h0));

  a_r7_quiet_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
endmodule

bind mdio_gw_master mdio_gw_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o),
  .busy_q      (busy_q),
  .cmd_q       (cmd_q)
);

// File: tb/mdio_gw_master_tb_top.sv
`timescale 1ns/1ps
module mdio_gw_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        mdc, mdio_out, oe, mdio_in;

  int checks = 0, fails = 0, cyc = 0;
  int rise_cnt, last_rise, bad_period, exp_period, smp_win;
  logic [63:0] seen_bits, seen_oe;
  logic [15:0] phy_rd;
  logic        is_rd_mon, prev_mdc;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_gw_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_i(mdio_in), .mdio_o(mdio_out), .mdio_oe_o(oe));

  function automatic logic [63:0] exp_frame(logic [1:0] op, logic [4:0] phy,
                                            logic [4:0] rg, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d};
  endfunction

  function automatic int clampv(int o, int d);
    return (o > d) ? d : o;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // PHY model: records bits on MDC rise, returns read data with a narrow valid window
  initial begin
    prev_mdc = 1'b0; mdio_in = 1'b0; rise_cnt = 0; last_rise = 0;
    bad_period = 0; exp_period = 2; smp_win = 1; is_rd_mon = 1'b0;
    seen_bits = '0; seen_oe = '0; phy_rd = '0;
    forever begin
      @(negedge clk);
      if (mdc && !prev_mdc) begin
        int k;
        k = rise_cnt;
        if (k > 0 && (cyc - last_rise) != exp_period) bad_period++;
        last_rise = cyc;
        if (k < 64) begin
          seen_bits[63-k] = mdio_out;
          seen_oe[63-k]   = oe;
        end
        rise_cnt++;
        prev_mdc = 1'b1;
        if (is_rd_mon && k >= 48 && k < 64) begin
          mdio_in = phy_rd[63-k];
          repeat (smp_win) @(posedge clk);
          #1 mdio_in = ~mdio_in;
        end
      end else begin
        prev_mdc = mdc;
      end
    end
  end

  task automatic reg_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic reg_rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic cfg_set(int div, int smp, int out, logic [3:0] opt);
    logic [31:0] d;
    reg_wr(4'h4, {out[7:0], smp[7:0], div[7:0], 3'b111, opt[3], 1'b1, opt[2], opt[1:0]});
    reg_rd(4'h4, d);
    chk("R2/R11", "cfg readback", {32'h0, d},
        {32'h0, out[7:0], smp[7:0], div[7:0], 3'b000, opt[3], 1'b0, opt[2], opt[1:0]});
  endtask

  task automatic start_cmd(logic [31:0] cmd, logic [15:0] rd, int div, int smp);
    exp_period = 2 * (div + 1);
    smp_win    = clampv(smp, div) + 1;
    phy_rd     = rd;
    is_rd_mon  = (cmd[27:26] == 2'b10);
    rise_cnt   = 0; bad_period = 0; seen_bits = '0; seen_oe = '0;
    reg_wr(4'h0, cmd);
  endtask

  task automatic finish_cmd(output logic [31:0] d);
    int guard;
    guard = 0;
    do begin
      reg_rd(4'h0, d);
      guard++;
    end while (d[30] && guard < 20000);
  endtask

  task automatic run_cmd(logic [1:0] op, logic [4:0] phy, logic [4:0] rg,
                         logic [15:0] data, logic [15:0] rd, int div, int smp, int out);
    logic [31:0] cmd, d;
    logic [63:0] ef;
    int n;
    cmd = {1'b0, 1'b1, 1'b0, 1'b1, op, phy, rg, data};
    ef  = exp_frame(op, phy, rg, data);
    start_cmd(cmd, rd, div, smp);
    n = 1;
    while (!oe && n < 600) begin @(negedge clk); n++; end
    chk("R7", "oe first rise delay", 64'(n), 64'(clampv(out, div) + 2));
    finish_cmd(d);
    chk("R3", "busy cleared", {63'h0, d[30]}, 64'h0);
    chk("R4", "mdc rising edges", 64'(rise_cnt), 64'd64);
    chk("R6", "mdc period errors", 64'(bad_period), 64'd0);
    chk("R6", "idle mdc/oe", {62'h0, mdc, oe}, 64'h0);
    if (op == 2'b10) begin
      chk("R5", "read header bits", {18'h0, seen_bits[63:18]}, {18'h0, ef[63:18]});
      chk("R5", "read oe pattern", seen_oe, {{46{1'b1}}, {18{1'b0}}});
      chk("R8", "read data captured", {48'h0, d[15:0]}, {48'h0, rd});
      chk("R2", "read fields kept", {35'h0, d[28:16]}, {35'h0, cmd[28:16]});
    end else begin
      chk("R4", "write frame bits", seen_bits, ef);
      chk("R4", "write oe pattern", seen_oe, {64{1'b1}});
      chk("R2", "write word readback", {32'h0, d}, {32'h0, cmd & 32'hBFFF_FFFF});
    end
  endtask

  task automatic finish_tb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_tb();
  end

  initial begin
    logic [31:0] d, cmd_a, cmd_b;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    reg_rd(4'h0, d); chk("R1", "gateway reset", {32'h0, d}, 64'h0);
    reg_rd(4'h4, d); chk("R1", "cfg reset", {32'h0, d}, 64'h0D06_5500);
    chk("R1", "reset mdc/oe", {62'h0, mdc, oe}, 64'h0);

    cfg_set(255, 255, 255, 4'hF);
    reg_wr(4'h8, 32'hFFFF_FFFF);
    reg_rd(4'h4, d); chk("R2", "stray offset leaves cfg", {32'h0, d}, 64'hFFFF_FF17);
    reg_rd(4'h0, d); chk("R2", "stray offset leaves gw", {32'h0, d}, 64'h0);

    reg_wr(4'h0, 32'hBABC_DEF0);
    repeat (10) @(negedge clk);
    reg_rd(4'h0, d); chk("R3", "store without busy", {32'h0, d}, 64'h1ABC_DEF0);
    chk("R3", "no frame without busy", {62'h0, mdc, oe}, 64'h0);

    // divider zero: shortest period, both offsets clamp
    cfg_set(0, 4, 7, 4'h0);
    run_cmd(2'b01, 5'h11, 5'h0A, 16'hA5C3, 16'h0, 0, 4, 7);
    run_cmd(2'b10, 5'h03, 5'h1F, 16'h0, 16'h9E41, 0, 4, 7);

    for (int i = 0; i < 8; i++) begin
      int dv, sm, ou;
      logic [1:0] op;
      dv = int'($urandom % 6);
      sm = int'($urandom % (dv + 1));
      ou = int'($urandom % 9);
      op = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
      cfg_set(dv, sm, ou, 4'($urandom));
      run_cmd(op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), dv, sm, ou);
    end

    // R9: non-zero write mid-frame
    cfg_set(2, 1, 1, 4'h0);
    cmd_a = {4'b0101, 2'b01, 5'h07, 5'h12, 16'h3C3C};
    cmd_b = {4'b0101, 2'b10, 5'h18, 5'h01, 16'hFFFF};
    start_cmd(cmd_a, 16'h0, 2, 1);
    repeat (40) @(negedge clk);
    reg_wr(4'h0, cmd_b);
    finish_cmd(d);
    chk("R9", "frame unaffected", seen_bits, exp_frame(2'b01, 5'h07, 5'h12, 16'h3C3C));
    chk("R9", "fields unaffected", {32'h0, d}, {32'h0, cmd_a & 32'hBFFF_FFFF});

    // R10: cancel mid-frame, then a normal frame
    start_cmd({4'b0101, 2'b10, 5'h02, 5'h04, 16'h0}, 16'h1234, 2, 1);
    repeat (100) @(negedge clk);
    reg_wr(4'h0, 32'h0);
    chk("R10", "bus idle after cancel", {62'h0, mdc, oe}, 64'h0);
    reg_rd(4'h0, d); chk("R10", "gateway zero after cancel", {32'h0, d}, 64'h0);
    begin
      int rc;
      rc = rise_cnt;
      repeat (30) @(negedge clk);
      chk("R10", "no mdc after cancel", 64'(rise_cnt), 64'(rc));
    end
    run_cmd(2'b01, 5'h1E, 5'h0F, 16'h0F0F, 16'h0, 2, 1, 1);

    // same-edge cases: period 4, frame ends 256 cycles after the accepting edge
    cfg_set(1, 0, 0, 4'h0);
    cmd_a = {4'b0101, 2'b01, 5'h0C, 5'h15, 16'hBEEF};
    start_cmd(cmd_a, 16'h0, 1, 0);
    repeat (254) @(negedge clk);
    reg_wr(4'h0, 32'h5000_0001);
    repeat (20) @(negedge clk);
    reg_rd(4'h0, d);
    chk("R9", "write at completion dropped", {32'h0, d}, {32'h0, cmd_a & 32'hBFFF_FFFF});
    chk("R9", "no extra frame", 64'(rise_cnt), 64'd64);

    start_cmd(cmd_a, 16'h0, 1, 0);
    repeat (254) @(negedge clk);
    reg_wr(4'h0, 32'h0);
    reg_rd(4'h0, d);
    chk("R10", "cancel wins at completion", {32'h0, d}, 64'h0);

    finish_tb();
  end
endmodule